// File: doc/BRIEF.md
# Phase Detector With Lock-Driven Charge Pump Current Control

This block compares the divided synthesizer pulse with the reference pulse of a frequency synthesizer and drives a charge pump. A three-state detector raises an UP pulse when the reference edge comes first and a DOWN pulse when the synthesizer edge comes first. The pulse lasts until the other edge arrives, so its width is the phase error. All timing is measured in cycles of a fast sampling clock, and both pulse inputs are sampled on that clock.

Each finished comparison is measured against a programmable window. A run of consecutive comparisons inside the window raises a lock flag. A comparison outside the window ends the run and drops the flag. The current-mode output starts in high current. It drops to low current on a reference edge, either because the block is locked while automatic switching is enabled, or because software asks for it while automatic switching is disabled. Writing new divider values is signalled by a one-cycle reprogram event. That event returns the pump to high current and restarts lock detection.

Top module: `pfd_lock_ctrl`

## Requirements
- R1: A rising edge of `ref_pls` that is not matched by a `syn_pls` edge sets `pump_up` from the next clock. A lone `syn_pls` rising edge sets `pump_dn` in the same way. `pump_up` and `pump_dn` are never high together. Rising edges on both inputs in the same cycle produce no pulse.
- R2: A pending pulse clears on the clock edge that samples the rising edge of the other input. `pump_up` or `pump_dn` therefore stays high for exactly as many cycles as separate the two edges. Further edges of the leading input are ignored while its pulse is pending.
- R3: The phase error of a comparison is its pulse width in clock cycles. Simultaneous edges count as an error of 0. A comparison is in lock when the error is at most `thr_sel`+1 cycles, so codes 0 to 3 allow 1 to 4 cycles.
- R4: `locked` is 1 while the count of consecutive in-lock comparisons is at least 2, 4, 8 or 16, for `cnt_sel` = 0 to 3. A comparison outside the window resets the count to 0. The count saturates at 16.
- R5: With `auto_en`=1, `low_cur` becomes 1 on the clock edge that samples a `ref_pls` rising edge while `locked` is 1. The switch therefore always falls on a reference edge.
- R6: With `auto_en`=0, `locked` has no effect on `low_cur`. `low_cur` becomes 1 on the clock edge that samples a `ref_pls` rising edge while `sw_low` is 1.
- R7: A `reprog` cycle clears `low_cur` (high current) and the in-lock count on the next edge. This holds even when a reference edge or a comparison would have switched or counted in the same cycle.
- R8: Once set, `low_cur` stays 1 until `reprog`, regardless of later phase errors.
- R9: After reset, `pump_up`, `pump_dn`, `low_cur` and `locked` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pls | input | 1 | Reference pulse |
| syn_pls | input | 1 | Divided synthesizer pulse |
| thr_sel | input | 2 | Lock window code: error of at most code+1 cycles |
| cnt_sel | input | 2 | Consecutive in-lock comparisons needed: 2, 4, 8 or 16 |
| auto_en | input | 1 | 1: low current follows lock; 0: follows `sw_low` |
| sw_low | input | 1 | Software low-current request |
| reprog | input | 1 | One-cycle event: divider values rewritten |
| pump_up | output | 1 | Charge pump UP pulse |
| pump_dn | output | 1 | Charge pump DOWN pulse |
| low_cur | output | 1 | 1 = low current, 0 = high current |
| locked | output | 1 | Lock flag |

## Verification
Two pairs of actions can fall in the same cycle, and the bench drives both on purpose.

The first pair is a reprogram event and a reference edge. The bench asserts `reprog` in exactly the cycle whose reference edge would otherwise switch a locked loop to low current. It then expects `low_cur` to stay 0 and the lock count to restart.

The second pair is a comparison closing and a reference edge being judged against the lock flag from before that comparison. The bench arranges this when the synthesizer edge leads. A cycle-by-cycle model running on every clock judges each case.

// File: rtl/pfd_lock_pkg.sv
`timescale 1ns/1ps
package pfd_lock_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_UP   = 2'd1,
      PH_DN   = 2'd2
   } ph_state_e;

   // Allowed error (in clock counts) for a window code
   function automatic int thr_limit(input int code, input int step);
      return (code + 1) * step;
   endfunction

   // In-lock comparisons needed for a count code
   function automatic int need_count(input int code, input int base_log2);
      return 1 << (code + base_log2);
   endfunction

endpackage

// File: rtl/pfd_lock_pfd.sv
`timescale 1ns/1ps
module pfd_lock_pfd
   import pfd_lock_pkg::*;
#(
   parameter int ERR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_i,
   input  logic             syn_i,
   output logic             up_o,
   output logic             dn_o,
   output logic             ref_edge_o,
   output logic             done_o,
   output logic [ERR_W-1:0] err_o
);

   localparam logic [ERR_W-1:0] ERR_MAX = '1;

   if (ERR_W < 3) begin : g_bad_err_w
      $error("pfd_lock_pfd: ERR_W must be at least 3");
   end

   ph_state_e        st, st_nx;
   logic             ref_q, syn_q;
   logic             ref_rise, syn_rise;
   logic             done;
   logic [ERR_W-1:0] w_cnt;

   assign ref_rise = ref_i & ~ref_q;
   assign syn_rise = syn_i & ~syn_q;

   always_comb begin
      st_nx = st;
      done  = 1'b0;
      unique case (st)
         PH_IDLE: begin
            if (ref_rise && syn_rise) done  = 1'b1;
            else if (ref_rise)        st_nx = PH_UP;
            else if (syn_rise)        st_nx = PH_DN;
         end
         PH_UP: begin
            if (syn_rise) begin
               done  = 1'b1;
               st_nx = PH_IDLE;
            end
         end
         PH_DN: begin
            if (ref_rise) begin
               done  = 1'b1;
               st_nx = PH_IDLE;
            end
         end
         default: st_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= PH_IDLE;
         ref_q <= 1'b0;
         syn_q <= 1'b0;
         w_cnt <= '0;
      end else begin
         st    <= st_nx;
         ref_q <= ref_i;
         syn_q <= syn_i;
         if (st == PH_IDLE || done) w_cnt <= '0;
         else if (w_cnt != ERR_MAX) w_cnt <= w_cnt + 1'b1;
      end
   end

   assign up_o       = (st == PH_UP);
   assign dn_o       = (st == PH_DN);
   assign ref_edge_o = ref_rise;
   assign done_o     = done;
   assign err_o      = (st == PH_IDLE)   ? '0      :
                       (w_cnt == ERR_MAX) ? ERR_MAX : w_cnt + 1'b1;

endmodule

// File: rtl/pfd_lock_det.sv
`timescale 1ns/1ps
module pfd_lock_det
   import pfd_lock_pkg::*;
#(
   parameter int SEL_W     = 2,
   parameter int ERR_W     = 6,
   parameter int THR_STEP  = 1,
   parameter int NEED_BASE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done_i,
   input  logic [ERR_W-1:0] err_i,
   input  logic [SEL_W-1:0] thr_sel,
   input  logic [SEL_W-1:0] cnt_sel,
   input  logic             clear_i,
   output logic             locked_o
);

   localparam int MAX_NEED = 1 << ((1 << SEL_W) - 1 + NEED_BASE);
   localparam int LK_W     = $clog2(MAX_NEED + 1);

   if ((1 << SEL_W) * THR_STEP >= (1 << ERR_W) - 1) begin : g_bad_thr
      $error("pfd_lock_det: largest window does not fit below error saturation");
   end
   if (MAX_NEED > 65536 || NEED_BASE < 1) begin : g_bad_need
      $error("pfd_lock_det: lock count range out of bounds");
   end

   logic [ERR_W-1:0] thr;
   logic [LK_W-1:0]  need;
   logic [LK_W-1:0]  lk_cnt;
   logic             in_win;

   assign thr    = ERR_W'(thr_limit(int'(thr_sel), THR_STEP));
   assign need   = LK_W'(need_count(int'(cnt_sel), NEED_BASE));
   assign in_win = (err_i <= thr);

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         lk_cnt <= '0;
      end else if (done_i) begin
         if (!in_win)                           lk_cnt <= '0;
         else if (lk_cnt != LK_W'(MAX_NEED))    lk_cnt <= lk_cnt + 1'b1;
      end
   end

   assign locked_o = (lk_cnt >= need);

endmodule

// File: rtl/pfd_lock_cur.sv
`timescale 1ns/1ps
module pfd_lock_cur #(
   parameter bit ALIGN_REF = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_edge_i,
   input  logic locked_i,
   input  logic auto_en,
   input  logic sw_low,
   input  logic reprog,
   output logic low_o
);

   logic want, trig;

   assign want = auto_en ? locked_i : sw_low;

   if (ALIGN_REF) begin : g_align
      assign trig = want & ref_edge_i;
   end else begin : g_direct
      logic unused_edge;
      assign unused_edge = ref_edge_i;
      assign trig        = want;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || reprog) low_o <= 1'b0;
      else if (trig)        low_o <= 1'b1;
   end

endmodule

// File: rtl/pfd_lock_ctrl.sv
`timescale 1ns/1ps
module pfd_lock_ctrl #(
   parameter int ERR_W     = 6,
   parameter int SEL_W     = 2,
   parameter int THR_STEP  = 1,
   parameter int NEED_BASE = 1,
   parameter bit ALIGN_REF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_pls,
   input  logic             syn_pls,
   input  logic [SEL_W-1:0] thr_sel,
   input  logic [SEL_W-1:0] cnt_sel,
   input  logic             auto_en,
   input  logic             sw_low,
   input  logic             reprog,
   output logic             pump_up,
   output logic             pump_dn,
   output logic             low_cur,
   output logic             locked
);

   logic             ref_edge, cmp_done;
   logic [ERR_W-1:0] cmp_err;

   pfd_lock_pfd #(.ERR_W(ERR_W)) i_pfd (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_i     (ref_pls),
      .syn_i     (syn_pls),
      .up_o      (pump_up),
      .dn_o      (pump_dn),
      .ref_edge_o(ref_edge),
      .done_o    (cmp_done),
      .err_o     (cmp_err)
   );

   pfd_lock_det #(
      .SEL_W    (SEL_W),
      .ERR_W    (ERR_W),
      .THR_STEP (THR_STEP),
      .NEED_BASE(NEED_BASE)
   ) i_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .done_i  (cmp_done),
      .err_i   (cmp_err),
      .thr_sel (thr_sel),
      .cnt_sel (cnt_sel),
      .clear_i (reprog),
      .locked_o(locked)
   );

   pfd_lock_cur #(.ALIGN_REF(ALIGN_REF)) i_cur (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_edge_i(ref_edge),
      .locked_i  (locked),
      .auto_en   (auto_en),
      .sw_low    (sw_low),
      .reprog    (reprog),
      .low_o     (low_cur)
   );

endmodule

// File: rtl/pfd_lock_chk.sv
`timescale 1ns/1ps
module pfd_lock_chk (
   input logic clk,
   input logic rst_n,
   input logic ref_pls,
   input logic auto_en,
   input logic sw_low,
   input logic reprog,
   input logic pump_up,
   input logic pump_dn,
   input logic low_cur,
   input logic locked
);

   // R1: never both pump directions at once
   p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(pump_up && pump_dn));

   // R7: reprogram restores high current and clears lock
   p_reprog_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reprog |=> (!low_cur && !locked));

   // R8: low current is held until reprogram
   p_low_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (low_cur && !reprog) |=> low_cur);

   // R5: the switch to low current lands on a sampled reference pulse
   p_low_on_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_cur) |-> ($past(ref_pls) && !$past(reprog)));

   // R6: the cause of the switch depends on the auto-enable bit
   p_low_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_cur) |-> ($past(auto_en) ? $past(locked) : $past(sw_low)));

endmodule

bind pfd_lock_ctrl pfd_lock_chk i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ref_pls(ref_pls),
   .auto_en(auto_en),
   .sw_low (sw_low),
   .reprog (reprog),
   .pump_up(pump_up),
   .pump_dn(pump_dn),
   .low_cur(low_cur),
   .locked (locked)
);

// File: tb/test_pfd_lock_ctrl.sv
`timescale 1ns/1ps
module test_pfd_lock_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_pls = 1'b0, syn_pls = 1'b0;
   logic [1:0] thr_sel = 2'd3, cnt_sel = 2'd0;
   logic       auto_en = 1'b1, sw_low = 1'b0, reprog = 1'b0;
   logic       pump_up, pump_dn, low_cur, locked;

   int errors = 0, checks = 0, wd = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pfd_lock_ctrl i_pfd_lock_ctrl (
      .clk(clk), .rst_n(rst_n), .ref_pls(ref_pls), .syn_pls(syn_pls),
      .thr_sel(thr_sel), .cnt_sel(cnt_sel), .auto_en(auto_en),
      .sw_low(sw_low), .reprog(reprog), .pump_up(pump_up),
      .pump_dn(pump_dn), .low_cur(low_cur), .locked(locked)
   );

   // Behavioural reference: timestamps of leading edges, integer lock run
   int m_lead = 0;   // 1 reference leads, -1 synthesizer leads, 0 none
   int m_start = 0, m_cyc = 0, m_run = 0, m_err = 0;
   bit m_rp = 0, m_sp = 0, m_low = 0, m_done = 0, m_lk_old = 0;
   bit rr = 0, sr = 0;

   function automatic int need_of(input int c);
      return 2 ** (c + 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lead = 0; m_run = 0; m_low = 0; m_rp = 0; m_sp = 0; m_cyc = 0;
      end else begin
         rr = ref_pls && !m_rp;
         sr = syn_pls && !m_sp;
         m_done = 0;
         m_lk_old = (m_run >= need_of(int'(cnt_sel)));
         if (m_lead == 0) begin
            if (rr && sr) begin m_done = 1; m_err = 0; end
            else if (rr) begin m_lead = 1;  m_start = m_cyc; end
            else if (sr) begin m_lead = -1; m_start = m_cyc; end
         end else if ((m_lead == 1 && sr) || (m_lead == -1 && rr)) begin
            m_done = 1; m_err = m_cyc - m_start; m_lead = 0;
         end
         if (reprog) m_run = 0;
         else if (m_done) begin
            if (m_err <= int'(thr_sel) + 1) m_run = (m_run < 16) ? m_run + 1 : 16;
            else m_run = 0;
         end
         if (reprog) m_low = 0;
         else if (rr && (auto_en ? m_lk_old : sw_low)) m_low = 1;
         m_rp = ref_pls; m_sp = syn_pls; m_cyc++;
      end
   end

   // Per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (pump_up !== (m_lead == 1) || pump_dn !== (m_lead == -1) ||
             low_cur !== m_low || locked !== (m_run >= need_of(int'(cnt_sel)))) begin
            errors++;
            $display("FAIL R1 R2 R4 R5 model: up/dn/low/lock=%b%b%b%b expected %b%b%b%b",
                     pump_up, pump_dn, low_cur, locked, (m_lead == 1), (m_lead == -1),
                     m_low, (m_run >= need_of(int'(cnt_sel))));
         end
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 100000 && !finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog: run did not end, actual=%0d expected<100000 cycles", wd);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   int up_cycles = 0, dn_cycles = 0;

   // One reference period of p cycles: ref rises at a, syn at b
   task automatic period(input int a, input int b, input int p, input bit rp);
      up_cycles = 0; dn_cycles = 0;
      for (int c = 0; c < p; c++) begin
         @(negedge clk);
         up_cycles += int'(pump_up);
         dn_cycles += int'(pump_dn);
         ref_pls = (c >= a && c < a + 2);
         syn_pls = (c >= b && c < b + 2);
         reprog  = rp && (c == a);
      end
   endtask

   task automatic do_reprog();
      @(negedge clk); reprog = 1'b1;
      @(negedge clk); reprog = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset pump_up", int'(pump_up), 0);
      check("R9 reset pump_dn", int'(pump_dn), 0);
      check("R9 reset low_cur", int'(low_cur), 0);
      check("R9 reset locked",  int'(locked), 0);

      // Reference leads by 3, window 4, need 2
      period(2, 5, 16, 0);
      check("R2 up width", up_cycles, 3);
      check("R1 no dn while ref leads", dn_cycles, 0);
      check("R4 one comparison not locked", int'(locked), 0);
      period(2, 5, 16, 0);
      check("R4 locked after two", int'(locked), 1);
      check("R5 not low before ref edge", int'(low_cur), 0);
      period(2, 5, 16, 0);
      check("R5 low after ref edge while locked", int'(low_cur), 1);

      do_reprog();
      check("R7 reprog high current", int'(low_cur), 0);
      check("R7 reprog clears lock", int'(locked), 0);

      // Synthesizer leads by 4 = window edge, need 4
      cnt_sel = 2'd1;
      for (int i = 0; i < 3; i++) period(6, 2, 16, 0);
      check("R1 dn width", dn_cycles, 4);
      check("R3 error 4 code 3 in window, 3 of 4", int'(locked), 0);
      period(6, 2, 16, 0);
      check("R4 locked after four", int'(locked), 1);

      // Tight window: error 2 with code 0 is out
      do_reprog();
      thr_sel = 2'd0; cnt_sel = 2'd0;
      for (int i = 0; i < 6; i++) period(2, 4, 16, 0);
      check("R3 error 2 outside code 0", int'(locked), 0);
      for (int i = 0; i < 2; i++) period(3, 4, 16, 0);
      check("R3 error 1 inside code 0", int'(locked), 1);
      period(2, 5, 16, 0);
      check("R4 large error clears lock", int'(locked), 0);
      check("R5 low taken at earlier ref edge", int'(low_cur), 1);
      for (int i = 0; i < 2; i++) period(2, 10, 16, 0);
      check("R8 low held despite large errors", int'(low_cur), 1);

      // Reprogram in the same cycle as a switching ref edge
      do_reprog();
      thr_sel = 2'd3;
      for (int i = 0; i < 2; i++) period(2, 3, 16, 0);
      check("R4 locked before collision", int'(locked), 1);
      period(2, 3, 16, 1);
      check("R7 reprog beats ref edge", int'(low_cur), 0);
      check("R7 count restarted", int'(locked), 0);

      // Software mode
      do_reprog();
      auto_en = 1'b0;
      for (int i = 0; i < 3; i++) period(2, 3, 16, 0);
      check("R6 locked in software mode", int'(locked), 1);
      check("R6 lock ignored for current", int'(low_cur), 0);
      sw_low = 1'b1;
      period(2, 3, 16, 0);
      check("R6 software low at ref edge", int'(low_cur), 1);
      sw_low = 1'b0;

      // Simultaneous edges, long count
      do_reprog();
      auto_en = 1'b1;
      period(4, 4, 16, 0);
      check("R1 simultaneous no up", up_cycles, 0);
      check("R1 simultaneous no dn", dn_cycles, 0);
      period(4, 4, 16, 0);
      check("R3 zero error counts in lock", int'(locked), 1);
      do_reprog();
      cnt_sel = 2'd3;
      for (int i = 0; i < 15; i++) period(2, 3, 16, 0);
      check("R4 fifteen of sixteen", int'(locked), 0);
      period(2, 3, 16, 0);
      check("R4 sixteen locks", int'(locked), 1);
      for (int i = 0; i < 4; i++) period(2, 3, 16, 0);
      check("R4 saturated stays locked", int'(locked), 1);

      repeat (3) @(negedge clk);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule